// File: doc/BRIEF.md
# Rotating Channel-Group Event Buffer Sequencer

This block controls a bank of eight analog sampling channels that can be chained, so that the sampling wave runs from one channel into the next. A two-bit partition code groups the channels into eight groups of one channel, four groups of two, two groups of four, or one group of all eight. This gives segments of 1024, 2048, 4096 or 8192 cells. Exactly one group samples at a time. The block drives one enable per channel, so the wave runs through every channel of the sampling group and through no other channel.

A trigger freezes the sampling group and places its index in an in-order readout queue. Sampling moves on to the next group in ring order, so a new event is written while older events are still being digitized. The readout side sees the oldest frozen group and a valid flag. It answers with a one-cycle done pulse, which releases that group. When every group holds an event, the block stops sampling and raises busy, and it ignores triggers. The first release restarts sampling in the group that was just freed.

Top module: `eb_seq`

## Requirements
- R1: After reset the partition code is 0, channel 0 alone is enabled, no channel is held, busy is low and no readout is offered.
- R2: While not busy, the enabled channels are exactly bits g·W to g·W+W−1 of the enable vector, with W = 2^code (code 0:W=1, 1:2, 2:4, 3:8), where g is the sampling group. No channel is ever both enabled and held.
- R3: A trigger while not busy and with no accepted partition load in the same cycle freezes the sampling group. Its channels appear in the held vector one cycle later, and sampling continues in group (g+1) mod (8/W).
- R4: The readout port offers frozen groups strictly in trigger order. The valid flag is high exactly when at least one channel is held.
- R5: A done pulse while valid is high releases the offered group, and its held bits clear on the next cycle.
- R6: When all groups are frozen, busy is high, all enables are low, and triggers change nothing.
- R7: A done pulse while busy clears busy on the next cycle and restarts sampling in the released group.
- R8: A partition load is accepted only while no channel is held. When accepted, it sets the code, restarts sampling in group 0 and discards a trigger in the same cycle. A load while channels are held has no effect.
- R9: A done pulse with no readout offered has no effect.
- R10: A trigger and a done pulse in the same non-busy cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger, freezes the sampling group |
| mode_i | input | 2 | Requested partition code |
| mode_load_i | input | 1 | Strobe to apply mode_i |
| rd_done_i | input | 1 | Readout of the offered group finished |
| chan_en_o | output | 8 | Per-channel enable for the sampling wave |
| chan_hold_o | output | 8 | Per-channel frozen-event status |
| busy_o | output | 1 | All groups hold events |
| rd_valid_o | output | 1 | A frozen group awaits readout |
| rd_group_o | output | 3 | Index of the oldest frozen group |
| mode_o | output | 2 | Partition code in force |

## Verification
A wrong sampling-group pointer shows up at the next edge as an enable pattern that is misplaced or overlaps a held channel. A corrupted readout queue shows up as a wrong offered index at the next done pulse. An error in the occupancy count shows up as busy rising one trigger early or late. The hold mask then diverges from the fill pattern that is expected after that trigger. Each of these faults is visible within one cycle of the event that exposes it, and every partition code is driven through fill, overflow, release and drain.

// File: rtl/eb_pkg.sv
package eb_pkg;
    localparam int unsigned EB_CH    = 8;
    localparam int unsigned EB_CHW   = $clog2(EB_CH);
    localparam int unsigned EB_MODEW = $clog2(EB_CHW + 1);
    localparam int unsigned EB_CNTW  = EB_CHW + 1;

    typedef logic [EB_CH-1:0]    eb_mask_t;
    typedef logic [EB_CHW-1:0]   eb_grp_t;
    typedef logic [EB_MODEW-1:0] eb_mode_t;
    typedef logic [EB_CNTW-1:0]  eb_cnt_t;

    // number of groups for a partition code
    function automatic eb_cnt_t eb_groups(input eb_mode_t m);
        return eb_cnt_t'(EB_CH >> m);
    endfunction
endpackage

// File: rtl/eb_grp_mask.sv
module eb_grp_mask
    import eb_pkg::*;
(
    input  eb_mode_t mode_i,
    input  eb_grp_t  grp_i,
    input  logic     en_i,
    output eb_mask_t mask_o
);
    for (genvar c = 0; c < EB_CH; c++) begin : g_bit
        localparam logic [EB_CHW-1:0] CIDX = c[EB_CHW-1:0];
        assign mask_o[c] = en_i && ((CIDX >> mode_i) == grp_i);
    end
endmodule

// File: rtl/eb_order_fifo.sv
module eb_order_fifo
    import eb_pkg::*;
#(
    parameter int unsigned DEPTH = EB_CH
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push_i,
    input  eb_grp_t data_i,
    input  logic    pop_i,
    output eb_grp_t head_o,
    output logic    empty_o,
    output eb_cnt_t count_o
);
    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][EB_CHW-1:0] slot;
        logic [AW-1:0]                rp;
        logic [AW-1:0]                wp;
        eb_cnt_t                      cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.slot[st_q.wp] = data_i;
            st_d.wp            = st_q.wp + 1'b1;
        end
        if (pop_i) begin
            st_d.rp = st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + eb_cnt_t'(push_i) - eb_cnt_t'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.slot[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign count_o = st_q.cnt;
endmodule

// File: rtl/eb_seq.sv
module eb_seq
    import eb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [1:0] mode_i,
    input  logic       mode_load_i,
    input  logic       rd_done_i,
    output logic [7:0] chan_en_o,
    output logic [7:0] chan_hold_o,
    output logic       busy_o,
    output logic       rd_valid_o,
    output logic [2:0] rd_group_o,
    output logic [1:0] mode_o
);
    typedef struct packed {
        eb_mode_t mode;
        eb_grp_t  wg;
        logic     busy;
        eb_mask_t hold;
    } seq_st_t;

    seq_st_t  st_d, st_q;

    eb_grp_t  head;
    logic     q_empty;
    eb_cnt_t  q_cnt;
    eb_mask_t wg_mask, head_mask;
    logic     push, pop, load_ok;

    eb_grp_mask u_wmask (
        .mode_i (st_q.mode),
        .grp_i  (st_q.wg),
        .en_i   (1'b1),
        .mask_o (wg_mask)
    );

    eb_grp_mask u_hmask (
        .mode_i (st_q.mode),
        .grp_i  (head),
        .en_i   (pop),
        .mask_o (head_mask)
    );

    eb_order_fifo #(.DEPTH(EB_CH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (st_q.wg),
        .pop_i   (pop),
        .head_o  (head),
        .empty_o (q_empty),
        .count_o (q_cnt)
    );

    always_comb begin
        eb_grp_t  gmax;
        eb_grp_t  nxt;
        eb_cnt_t  cnt_nx;
        eb_mask_t push_mask;

        st_d    = st_q;
        load_ok = mode_load_i && q_empty;
        pop     = rd_done_i && !q_empty;
        push    = trig_i && !st_q.busy && !load_ok;

        gmax      = eb_grp_t'(eb_groups(st_q.mode) - 1'b1);
        nxt       = (st_q.wg + 1'b1) & gmax;
        cnt_nx    = q_cnt + eb_cnt_t'(push) - eb_cnt_t'(pop);
        push_mask = push ? wg_mask : '0;

        if (load_ok) begin
            st_d.mode = eb_mode_t'(mode_i);
            st_d.wg   = '0;
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            if (pop) begin
                st_d.wg   = head;
                st_d.busy = 1'b0;
            end
        end else if (push) begin
            st_d.wg   = nxt;
            st_d.busy = (cnt_nx == eb_groups(st_q.mode));
        end

        st_d.hold = (st_q.hold & ~head_mask) | push_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_en_o   = st_q.busy ? '0 : wg_mask;
    assign chan_hold_o = st_q.hold;
    assign busy_o      = st_q.busy;
    assign rd_valid_o  = !q_empty;
    assign rd_group_o  = head;
    assign mode_o      = st_q.mode;
endmodule

// File: rtl/eb_seq_chk.sv
module eb_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_i,
    input logic [1:0] mode_i,
    input logic       mode_load_i,
    input logic       rd_done_i,
    input logic [7:0] chan_en_o,
    input logic [7:0] chan_hold_o,
    input logic       busy_o,
    input logic       rd_valid_o,
    input logic [2:0] rd_group_o,
    input logic [1:0] mode_o
);
    // R2
    en_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ($countones(chan_en_o) == (1 << mode_o)));

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en_o & chan_hold_o) == 8'h00);

    // R3
    trig_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !busy_o && !mode_load_i) |=>
        ((chan_hold_o & $past(chan_en_o)) == $past(chan_en_o)));

    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o == (chan_hold_o != 8'h00));

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (chan_en_o == 8'h00));

    // R8
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_hold_o != 8'h00) |=> $stable(mode_o));

    // R9
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && !rd_valid_o && !trig_i) |=> $stable(chan_hold_o));
endmodule

bind eb_seq eb_seq_chk u_chk (.*);

// File: tb/sim_eb_seq.sv
module sim_eb_seq;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       mode_load_i = 1'b0;
    logic       rd_done_i = 1'b0;
    logic [7:0] chan_en_o, chan_hold_o;
    logic       busy_o, rd_valid_o;
    logic [2:0] rd_group_o;
    logic [1:0] mode_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    eb_seq u0 (.*);

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic step(input logic t, input logic r, input logic l, input logic [1:0] m);
        @(negedge clk);
        trig_i = t; rd_done_i = r; mode_load_i = l; mode_i = m;
        @(posedge clk);
        @(negedge clk);
        trig_i = 0; rd_done_i = 0; mode_load_i = 0;
    endtask

    function automatic int gm(input int g, input int w);
        return (((1 << w) - 1) << (g * w)) & 8'hFF;
    endfunction

    initial begin
        int w, g, ew, eh, ex;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", chan_en_o, 8'h01);
        chk("R1 hold", chan_hold_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 valid", rd_valid_o, 0);
        chk("R1 mode", mode_o, 0);

        for (int m = 0; m < 4; m++) begin
            w = 1 << m;
            g = 8 >> m;
            step(0, 0, 1, 2'(m));
            chk("R8 load", mode_o, m);
            chk("R2 en", chan_en_o, gm(0, w));
            chk("R2 hold", chan_hold_o, 0);
            // fill all groups
            for (int k = 0; k < g; k++) begin
                step(1, 0, 0, 0);
                chk("R3 hold", chan_hold_o, ((1 << ((k + 1) * w)) - 1) & 8'hFF);
                if (k < g - 1) begin
                    chk("R3 en", chan_en_o, gm(k + 1, w));
                    chk("R3 busy", busy_o, 0);
                end else begin
                    chk("R6 busy", busy_o, 1);
                    chk("R6 en", chan_en_o, 0);
                end
            end
            step(1, 0, 0, 0);
            chk("R6 ignored trig", chan_hold_o, 8'hFF);
            chk("R6 still busy", busy_o, 1);
            step(0, 0, 1, 2'((m + 1) % 4));
            chk("R8 rejected", mode_o, m);
            chk("R4 oldest", rd_group_o, 0);
            chk("R4 valid", rd_valid_o, 1);
            step(0, 1, 0, 0);
            chk("R7 busy", busy_o, 0);
            chk("R7 en", chan_en_o, gm(0, w));
            chk("R5 release", chan_hold_o, 8'hFF & ~gm(0, w));
            step(1, 0, 0, 0);
            chk("R6 refill", busy_o, 1);
            chk("R3 refill hold", chan_hold_o, 8'hFF);
            // drain in trigger order
            eh = 8'hFF;
            for (int i = 0; i < g; i++) begin
                ex = (i + 1) % g;
                chk("R4 order", rd_group_o, ex);
                step(0, 1, 0, 0);
                eh = eh & ~gm(ex, w);
                chk("R5 clear", chan_hold_o, eh);
            end
            chk("R4 empty", rd_valid_o, 0);
            ew = 1 % g;
            chk("R7 resumed", chan_en_o, gm(ew, w));
            step(0, 1, 0, 0);
            chk("R9 hold", chan_hold_o, 0);
            chk("R9 en", chan_en_o, gm(ew, w));
            chk("R9 valid", rd_valid_o, 0);
            if (g >= 2) begin
                step(1, 0, 0, 0);
                chk("R10 pre", chan_hold_o, gm(ew, w));
                step(1, 1, 0, 0);
                chk("R10 hold", chan_hold_o, gm((ew + 1) % g, w));
                chk("R10 en", chan_en_o, gm((ew + 2) % g, w));
                chk("R10 head", rd_group_o, (ew + 1) % g);
                step(0, 1, 0, 0);
                chk("R10 drain", chan_hold_o, 0);
            end
            step(1, 0, 1, 2'(m));
            chk("R8 trig dropped", chan_hold_o, 0);
            chk("R8 restart", chan_en_o, gm(0, w));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule